// File: doc/BRIEF.md
# Address-Size-Qualified Request Decoder

This block is the request-phase front end of a memory response agent on a shared processor bus with several agents. A requester drives the first packet of a request together with an active-low strobe. The packet holds a qword address (bits 35:3), a 5-bit transaction type and a 2-bit address-size code, all active low. In the strobe cycle the block registers the packet in true polarity. In the same edge it registers the decision on whether this agent owns the request.

A parameter fixes the agent's decode width at 32 or 36 bits. The agent claims a request only when three conditions hold. The transaction type must be a memory read or a memory write. The size code must be one that the agent's width may decode. The address, seen over that width, must lie in an inclusive window that parameters set at qword granularity. This gate keeps a narrow agent from answering to the low bits of an address meant for a wider target. Packet B, snooping, the response phase and data transfer are handled elsewhere.

Top module: `reqdec_top`

## Requirements
- R1: While `rst` is high at a rising edge, and after that edge, `hit` is 0 and `cap_addr`, `cap_type` and `cap_size` are all zero.
- R2: When `ads_n` is sampled low, the next cycle shows the bitwise inverse of `addr_n`, `reqtype_n` and `size_n` on `cap_addr`, `cap_type` and `cap_size`. When `ads_n` is sampled high, those outputs keep their values.
- R3: A claimed request raises `hit` for exactly the one cycle that follows the edge where `ads_n` was sampled low. `hit` is 0 in any cycle that does not follow such an edge. Strobes on consecutive edges give `hit` in consecutive cycles.
- R4: Only true-polarity type 5'b01000 (memory read) or 5'b01001 (memory write) can be claimed. Every other type code gives `hit` = 0.
- R5: True-polarity size code 2'b00 means an address below 4 GB and 2'b01 means an address below 64 GB. Codes 2'b10 and 2'b11 are reserved and never give `hit`, on either agent width.
- R6: A 32-bit agent (`AGENT_W`=32) never claims a request with size code 2'b01, even when address bits 31:3 fall inside its window.
- R7: With size code 2'b00, address bits 35:32 are ignored and treated as zero, on both agent widths.
- R8: A 36-bit agent (`AGENT_W`=36) with size code 2'b01 compares all of bits 35:3 against its window.
- R9: The window is inclusive. The addresses at qword index `QW_BASE` and at `QW_LIMIT` are claimed. The qword just below the base and the qword just above the limit are not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ads_n | input | 1 | Request strobe for the first packet, active low |
| addr_n | input | 33 | Qword address bits 35:3, active low |
| reqtype_n | input | 5 | Transaction type, active low |
| size_n | input | 2 | Address-size code, active low |
| hit | output | 1 | One-cycle claim pulse for this agent |
| cap_addr | output | 33 | Captured qword address, true polarity |
| cap_type | output | 5 | Captured transaction type, true polarity |
| cap_size | output | 2 | Captured size code, true polarity |

## Verification
The bench builds two instances side by side and drives the same bus into both. The first is a 32-bit agent with a window from 0x1000_0000 to 0x1FFF_FFF8. The second is a 36-bit agent with a window from 0x2_0000_0000 to 0x2_FFFF_FFF8. Each stimulus is therefore judged at both widths. The pairing makes the aliasing case testable: an address above 4 GB whose low 32 bits fall in the narrow window, with the size code set to 2'b01, must be ignored by the narrow agent and claimed by the wide one. The same setup checks that bits 35:32 are masked under the 4 GB code and that all four window edges behave correctly.

// File: rtl/reqdec_pkg.sv
package reqdec_pkg;

    localparam int QW_W   = 33;   // qword address bits 35:3
    localparam int TYPE_W = 5;
    localparam int SIZE_W = 2;
    localparam int LOW_QW = 29;   // qword bits covering a 32-bit byte address

    typedef logic [QW_W-1:0]   qword_t;
    typedef logic [TYPE_W-1:0] rtype_t;

    typedef enum logic [SIZE_W-1:0] {
        SZ_BELOW_4G  = 2'b00,
        SZ_BELOW_64G = 2'b01,
        SZ_RSV_A     = 2'b10,
        SZ_RSV_B     = 2'b11
    } size_e;

    typedef struct packed {
        qword_t addr;
        rtype_t rtype;
        size_e  size;
    } req_pkt_t;

    localparam rtype_t RT_MEM_RD = 5'b01000;
    localparam rtype_t RT_MEM_WR = 5'b01001;

    function automatic logic is_mem_type(rtype_t t);
        return (t == RT_MEM_RD) || (t == RT_MEM_WR);
    endfunction

    function automatic logic size_allowed(size_e s, int agent_w);
        if (agent_w == 32)
            return s == SZ_BELOW_4G;
        else
            return (s == SZ_BELOW_4G) || (s == SZ_BELOW_64G);
    endfunction

endpackage

// File: rtl/reqdec_capture.sv
module reqdec_capture
    import reqdec_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                ads_n,
    input  logic [QW_W-1:0]     addr_n,
    input  logic [TYPE_W-1:0]   reqtype_n,
    input  logic [SIZE_W-1:0]   size_n,
    output logic                strobe,
    output req_pkt_t            req_now,
    output req_pkt_t            req_cap
);

    // single point of polarity inversion
    always_comb begin
        strobe        = ~ads_n;
        req_now.addr  = ~addr_n;
        req_now.rtype = ~reqtype_n;
        req_now.size  = size_e'(~size_n);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_cap <= '0;
        end else if (strobe) begin
            req_cap <= req_now;
        end
    end

endmodule

// File: rtl/reqdec_qualify.sv
module reqdec_qualify
    import reqdec_pkg::*;
#(
    parameter int AGENT_W = 32
)(
    input  req_pkt_t req,
    output logic     sel_ok,
    output qword_t   eff_addr
);

    always_comb begin
        sel_ok = is_mem_type(req.rtype) && size_allowed(req.size, AGENT_W);
        if (req.size == SZ_BELOW_4G)
            eff_addr = {{(QW_W-LOW_QW){1'b0}}, req.addr[LOW_QW-1:0]};
        else
            eff_addr = req.addr;
    end

endmodule

// File: rtl/reqdec_window.sv
module reqdec_window
    import reqdec_pkg::*;
#(
    parameter int     AGENT_W  = 32,
    parameter qword_t QW_BASE  = '0,
    parameter qword_t QW_LIMIT = '1
)(
    input  qword_t eff_addr,
    output logic   in_win
);

    localparam int CMP_W = AGENT_W - 3;
    localparam logic [CMP_W-1:0] BASE_C  = QW_BASE[CMP_W-1:0];
    localparam logic [CMP_W-1:0] LIMIT_C = QW_LIMIT[CMP_W-1:0];

    logic [CMP_W-1:0] low_part;
    logic             upper_clear;
    logic             ge_base;
    logic             le_limit;

    assign low_part = eff_addr[CMP_W-1:0];

    generate
        if (CMP_W < QW_W) begin : g_narrow
            assign upper_clear = (eff_addr[QW_W-1:CMP_W] == '0);
        end else begin : g_full
            assign upper_clear = 1'b1;
        end
    endgenerate

    assign ge_base  = (low_part >= BASE_C);
    assign le_limit = (low_part <= LIMIT_C);
    assign in_win   = upper_clear && ge_base && le_limit;

endmodule

// File: rtl/reqdec_top.sv
module reqdec_top
    import reqdec_pkg::*;
#(
    parameter int     AGENT_W  = 32,
    parameter qword_t QW_BASE  = 33'h0200_0000,
    parameter qword_t QW_LIMIT = 33'h03FF_FFFF
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              ads_n,
    input  logic [QW_W-1:0]   addr_n,
    input  logic [TYPE_W-1:0] reqtype_n,
    input  logic [SIZE_W-1:0] size_n,
    output logic              hit,
    output logic [QW_W-1:0]   cap_addr,
    output logic [TYPE_W-1:0] cap_type,
    output logic [SIZE_W-1:0] cap_size
);

    logic     strobe;
    req_pkt_t req_now;
    req_pkt_t req_cap;
    logic     sel_ok;
    qword_t   eff_addr;
    logic     in_win;
    logic     hit_q;

    reqdec_capture u_capture (
        .clk       (clk),
        .rst       (rst),
        .ads_n     (ads_n),
        .addr_n    (addr_n),
        .reqtype_n (reqtype_n),
        .size_n    (size_n),
        .strobe    (strobe),
        .req_now   (req_now),
        .req_cap   (req_cap)
    );

    reqdec_qualify #(.AGENT_W(AGENT_W)) u_qualify (
        .req      (req_now),
        .sel_ok   (sel_ok),
        .eff_addr (eff_addr)
    );

    reqdec_window #(
        .AGENT_W  (AGENT_W),
        .QW_BASE  (QW_BASE),
        .QW_LIMIT (QW_LIMIT)
    ) u_window (
        .eff_addr (eff_addr),
        .in_win   (in_win)
    );

    always_ff @(posedge clk) begin
        if (rst) hit_q <= 1'b0;
        else     hit_q <= strobe && sel_ok && in_win;
    end

    assign hit      = hit_q;
    assign cap_addr = req_cap.addr;
    assign cap_type = req_cap.rtype;
    assign cap_size = req_cap.size;

endmodule

// File: rtl/reqdec_checks.sv
module reqdec_checks #(
    parameter int AGENT_W = 32
)(
    input logic        clk,
    input logic        rst,
    input logic        ads_n,
    input logic [32:0] addr_n,
    input logic [4:0]  reqtype_n,
    input logic [1:0]  size_n,
    input logic        hit,
    input logic [32:0] cap_addr,
    input logic [4:0]  cap_type,
    input logic [1:0]  cap_size
);

    logic [4:0] type_t;
    logic [1:0] size_t;
    assign type_t = ~reqtype_n;
    assign size_t = ~size_n;

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!hit && cap_addr == '0 && cap_type == '0 && cap_size == '0));

    p_capture_r2: assert property (@(posedge clk) disable iff (rst)
        !ads_n |=> (cap_addr == ~$past(addr_n) && cap_type == ~$past(reqtype_n)
                    && cap_size == ~$past(size_n)));

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        ads_n |=> ($stable(cap_addr) && $stable(cap_type) && $stable(cap_size)));

    p_hit_needs_strobe_r3: assert property (@(posedge clk) disable iff (rst)
        ads_n |=> !hit);

    p_nonmem_r4: assert property (@(posedge clk) disable iff (rst)
        (!ads_n && type_t != 5'b01000 && type_t != 5'b01001) |=> !hit);

    p_reserved_r5: assert property (@(posedge clk) disable iff (rst)
        (!ads_n && size_t[1]) |=> !hit);

    generate
        if (AGENT_W == 32) begin : g_narrow_chk
            p_no_alias_r6: assert property (@(posedge clk) disable iff (rst)
                (!ads_n && size_t == 2'b01) |=> !hit);
        end
    endgenerate

endmodule

bind reqdec_top reqdec_checks #(.AGENT_W(AGENT_W)) u_checks (
    .clk       (clk),
    .rst       (rst),
    .ads_n     (ads_n),
    .addr_n    (addr_n),
    .reqtype_n (reqtype_n),
    .size_n    (size_n),
    .hit       (hit),
    .cap_addr  (cap_addr),
    .cap_type  (cap_type),
    .cap_size  (cap_size)
);

// File: tb/reqdec_top_bench.sv
`timescale 1ns/1ps
module reqdec_top_bench;

    localparam logic [35:0] N_BASE  = 36'h0_1000_0000;
    localparam logic [35:0] N_LIMIT = 36'h0_1FFF_FFF8;
    localparam logic [35:0] W_BASE  = 36'h2_0000_0000;
    localparam logic [35:0] W_LIMIT = 36'h2_FFFF_FFF8;
    localparam logic [4:0]  T_RD  = 5'b01000;
    localparam logic [4:0]  T_WR  = 5'b01001;

    logic        clk = 1'b0;
    logic        rst;
    logic        ads_n;
    logic [32:0] addr_n;
    logic [4:0]  reqtype_n;
    logic [1:0]  size_n;
    logic        hit_n32, hit_w36;
    logic [32:0] cap_addr_n32, cap_addr_w36;
    logic [4:0]  cap_type_n32, cap_type_w36;
    logic [1:0]  cap_size_n32, cap_size_w36;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    reqdec_top #(.AGENT_W(32), .QW_BASE(N_BASE[35:3]), .QW_LIMIT(N_LIMIT[35:3])) u_reqdec_top (
        .clk(clk), .rst(rst), .ads_n(ads_n), .addr_n(addr_n), .reqtype_n(reqtype_n),
        .size_n(size_n), .hit(hit_n32), .cap_addr(cap_addr_n32),
        .cap_type(cap_type_n32), .cap_size(cap_size_n32));

    reqdec_top #(.AGENT_W(36), .QW_BASE(W_BASE[35:3]), .QW_LIMIT(W_LIMIT[35:3])) u_reqdec_top_w36 (
        .clk(clk), .rst(rst), .ads_n(ads_n), .addr_n(addr_n), .reqtype_n(reqtype_n),
        .size_n(size_n), .hit(hit_w36), .cap_addr(cap_addr_w36),
        .cap_type(cap_type_w36), .cap_size(cap_size_w36));

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // expected claim from the requirements
    function automatic logic model(input int aw, input logic [35:0] a,
                                   input logic [4:0] t, input logic [1:0] s);
        logic [35:0] ea;
        logic [35:0] lo, hi;
        lo = (aw == 32) ? N_BASE  : W_BASE;
        hi = (aw == 32) ? N_LIMIT : W_LIMIT;
        if (t != T_RD && t != T_WR) return 1'b0;
        if (s == 2'b00)                 ea = {4'h0, a[31:0]};
        else if (s == 2'b01 && aw == 36) ea = a;
        else return 1'b0;
        return (ea >= lo) && (ea <= hi);
    endfunction

    task automatic idle();
        ads_n = 1'b1; addr_n = '1; reqtype_n = '1; size_n = '1;
    endtask

    // one strobe; checks capture, the pulse and its fall
    task automatic send(input string tag, input logic [35:0] a,
                        input logic [4:0] t, input logic [1:0] s);
        @(negedge clk);
        ads_n = 1'b0; addr_n = ~a[35:3]; reqtype_n = ~t; size_n = ~s;
        @(negedge clk);
        chk({tag, " R3 hit n32"}, hit_n32, model(32, a, t, s));
        chk({tag, " R3 hit w36"}, hit_w36, model(36, a, t, s));
        chk({tag, " R2 cap_addr"}, cap_addr_n32, a[35:3]);
        chk({tag, " R2 cap_type"}, cap_type_w36, t);
        chk({tag, " R2 cap_size"}, cap_size_n32, s);
        idle();
        @(negedge clk);
        chk({tag, " R3 fall n32"}, hit_n32, 1'b0);
        chk({tag, " R3 fall w36"}, hit_w36, 1'b0);
    endtask

    task automatic t_reset();
        chk("R1 hit n32", hit_n32, 1'b0);
        chk("R1 hit w36", hit_w36, 1'b0);
        chk("R1 cap_addr", cap_addr_n32, '0);
        chk("R1 cap_type", cap_type_w36, '0);
        chk("R1 cap_size", cap_size_n32, '0);
    endtask

    task automatic t_basic();
        send("R3 rd low",  36'h0_1234_5678, T_RD, 2'b00);
        chk("R3 direct n32 claimed", model(32, 36'h0_1234_5678, T_RD, 2'b00), 1'b1);
        send("R4 wr low",  36'h0_1800_0000, T_WR, 2'b00);
        send("R8 rd high", 36'h2_4000_0008, T_RD, 2'b01);
    endtask

    task automatic t_nonmem();
        send("R4 type 00000", 36'h0_1000_0000, 5'b00000, 2'b00);
        send("R4 type 11111", 36'h2_1000_0000, 5'b11111, 2'b01);
        send("R4 type 01010", 36'h0_1000_0000, 5'b01010, 2'b00);
    endtask

    task automatic t_reserved();
        send("R5 code 10 low",  36'h0_1000_0000, T_RD, 2'b10);
        send("R5 code 11 low",  36'h0_1000_0000, T_WR, 2'b11);
        send("R5 code 10 high", 36'h2_1000_0000, T_RD, 2'b10);
        send("R5 code 11 high", 36'h2_1000_0000, T_RD, 2'b11);
    endtask

    task automatic t_alias();
        // low 32 bits inside the narrow window, full address above 4 GB
        send("R6 R8 alias", 36'h2_1000_0000, T_RD, 2'b01);
        chk("R6 narrow ignores", model(32, 36'h2_1000_0000, T_RD, 2'b01), 1'b0);
        chk("R8 wide claims",    model(36, 36'h2_1000_0000, T_RD, 2'b01), 1'b1);
        send("R6 alias wr", 36'h3_1FFF_FFF8, T_WR, 2'b01);
    endtask

    task automatic t_upper_ignored();
        send("R7 upper F", 36'hF_1000_0000, T_RD, 2'b00);
        send("R7 upper 2", 36'h2_1000_0000, T_WR, 2'b00);
    endtask

    task automatic t_bounds();
        send("R9 n base",    N_BASE,              T_RD, 2'b00);
        send("R9 n below",   N_BASE - 36'd8,      T_RD, 2'b00);
        send("R9 n limit",   N_LIMIT,             T_RD, 2'b00);
        send("R9 n above",   N_LIMIT + 36'd8,     T_RD, 2'b00);
        send("R9 w base",    W_BASE,              T_RD, 2'b01);
        send("R9 w below",   W_BASE - 36'd8,      T_RD, 2'b01);
        send("R9 w limit",   W_LIMIT,             T_WR, 2'b01);
        send("R9 w above",   W_LIMIT + 36'd8,     T_WR, 2'b01);
    endtask

    task automatic t_no_strobe();
        logic [32:0] held;
        send("R2 prime", 36'h0_1111_1110, T_RD, 2'b00);
        held = cap_addr_n32;
        @(negedge clk);
        ads_n = 1'b1; addr_n = ~N_BASE[35:3]; reqtype_n = ~T_RD; size_n = 2'b11;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R3 no strobe n32", hit_n32, 1'b0);
            chk("R3 no strobe w36", hit_w36, 1'b0);
            chk("R2 hold cap_addr", cap_addr_n32, held);
        end
        idle();
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        ads_n = 1'b0; addr_n = ~N_BASE[35:3]; reqtype_n = ~T_RD; size_n = 2'b11;
        @(negedge clk);
        chk("R3 b2b first", hit_n32, 1'b1);
        addr_n = ~W_BASE[35:3]; size_n = 2'b10;   // size code 01
        @(negedge clk);
        chk("R3 b2b second n32", hit_n32, 1'b0);
        chk("R3 b2b second w36", hit_w36, 1'b1);
        idle();
        @(negedge clk);
        chk("R3 b2b end", hit_w36, 1'b0);
    endtask

    initial begin
        #(200000 * 5.0);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        idle();
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_basic();
        t_nonmem();
        t_reserved();
        t_alias();
        t_upper_ignored();
        t_bounds();
        t_no_strobe();
        t_back_to_back();
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule